// File: doc/BRIEF.md
# Keyed Window Watchdog Timer

This block is a watchdog timer that software has to service on time, or else it asks the system to reset. A 32-bit counter advances on a divided tick. The tick comes either from an external low-rate strobe or from the bus clock, and a small prescaler divides it. Software services the counter by writing two fixed words, in order, to a service register. It can also demand that service not arrive too early (window mode). If the counter reaches the timeout, the block raises an early-warning interrupt. A fixed grace period later it pulses a reset request.

Configuration is protected. Software writes two unlock words in order, and only then does a short configuration period open. A sticky permission bit can lock the configuration for good until the next reset. A self-test mode runs the counter one byte lane at a time, or in full, so that every lane of the comparator can be exercised without waiting through a full 32-bit count.

The bus is a single-cycle write port and a combinational read port, on eight 16-bit word addresses.

Top module: `wdt_keyed`

## Requirements
- R1: Configuration registers (addresses 0 to 5) change only after 0xC520 and then 0xD928 are written to address 6. A wrong value, a reversed order or an interposed wrong word at address 6 leaves every configuration register unchanged.
- R2: A configuration write is accepted on any of the 256 clock edges that follow the edge that took 0xD928, and is rejected from the 257th edge on.
- R3: Once the control bit 4 (update permission) holds 0, no configuration register can be written again until reset, even after a correct unlock.
- R4: Map and reset values are as follows. Address 0 is control and resets to 0x0011. Address 1 holds timeout bits 31:16 and address 2 holds bits 15:0, resetting to 0x0000FFFF. Addresses 3 and 4 hold the window value in the same way, resetting to 0. Address 5 is the prescaler, resetting to 0. Reads of 6 and 7 return counter bits 31:16 and 15:0.
- R5: Control bit 1 selects the tick source: 1 means every clock, 0 means `lp_tick_i` pulses. The counter advances once per (prescaler+1) source pulses.
- R6: Writing 0xA602 and then 0xB480 to address 7 clears the counter to 0 and cancels a pending warning.
- R7: Any other word at address 7 where 0xA602 or 0xB480 is expected is a fault. A fault clears the counter and gives a one-cycle `rst_req_o` on the next cycle.
- R8: When control bit 3 (window mode) is set, a valid service while the counter is below the window value is a fault.
- R9: When the counter reaches the timeout, `irq_o` rises one cycle later if control bit 2 is set, and stays high for 128 cycles. Then `rst_req_o` pulses for one cycle and the counter restarts from 0.
- R10: The counter holds while `dbg_i`, `stop_i` or `wait_i` is high and the matching run bit (control bits 5, 6, 7) is 0.
- R11: With control bit 11 set and bit 12 clear, test mode is active and `irq_o` stays low. When bit 8 is 0, the counter steps by one in the byte lane chosen by bits 10:9, and only that lane is compared with the timeout. Setting bit 12 restores normal counting.
- R12: With control bit 0 clear, the counter holds 0, service writes are ignored and no reset request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_tick_i | input | 1 | Low-rate tick strobe, one clock wide |
| dbg_i | input | 1 | System is in debug halt |
| stop_i | input | 1 | System is in stop mode |
| wait_i | input | 1 | System is in wait mode |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Early warning before reset |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest situation to reach is the edge of the configuration period, exactly 256 and 257 edges after the second key. The stimulus counts idle cycles from the key write so that one write lands on the last accepting edge and a repeat lands one edge later. Read-back then shows which of the two took effect. The early-service fault is also awkward to reach, because the counter must sit below the window value at the moment service arrives. The stimulus first forces a fault on purpose, which zeroes the counter, and then services at once. Test mode uses a timeout in lane 1, so that a full grace sequence with the interrupt held low completes within a few hundred cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam logic [15:0] KEY_OPEN_1 = 16'hC520;
   localparam logic [15:0] KEY_OPEN_2 = 16'hD928;
   localparam logic [15:0] KEY_SVC_1  = 16'hA602;
   localparam logic [15:0] KEY_SVC_2  = 16'hB480;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_TMO_H = 3'd1;
   localparam logic [ADDR_W-1:0] A_TMO_L = 3'd2;
   localparam logic [ADDR_W-1:0] A_WIN_H = 3'd3;
   localparam logic [ADDR_W-1:0] A_WIN_L = 3'd4;
   localparam logic [ADDR_W-1:0] A_PRESC = 3'd5;
   localparam logic [ADDR_W-1:0] A_KEY   = 3'd6;
   localparam logic [ADDR_W-1:0] A_SVC   = 3'd7;

   // control word, bit 12 down to bit 0
   typedef struct packed {
      logic       tst_block;
      logic       tst_en;
      logic [1:0] byte_sel;
      logic       tst_full;
      logic       wait_run;
      logic       stop_run;
      logic       dbg_run;
      logic       allow;
      logic       win_en;
      logic       irq_en;
      logic       clk_sel;
      logic       en;
   } wdt_ctrl_t;

   localparam int CTRL_W = $bits(wdt_ctrl_t);
   localparam logic [CTRL_W-1:0] CTRL_RST = 13'h0011;

   // fields the counter path needs
   typedef struct packed {
      logic       en;
      logic       clk_sel;
      logic       win_en;
      logic       dbg_run;
      logic       stop_run;
      logic       wait_run;
      logic       tst_full;
      logic [1:0] byte_sel;
      logic       tst_en;
      logic       tst_block;
   } wdt_run_t;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
   import wdt_pkg::*;
#(
   parameter int WIN_LEN = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [15:0] key_data,
   output logic        open_o
);
   localparam int WC_W = $clog2(WIN_LEN);

   logic            key1;
   logic            open;
   logic [WC_W-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key1 <= 1'b0;
         open <= 1'b0;
         wcnt <= '0;
      end else if (open) begin
         if (wcnt == WC_W'(WIN_LEN - 1)) open <= 1'b0;
         else                            wcnt <= wcnt + 1'b1;
      end else if (key_wr) begin
         if (key1 && key_data == KEY_OPEN_2) begin
            open <= 1'b1;
            wcnt <= '0;
            key1 <= 1'b0;
         end else begin
            key1 <= (key_data == KEY_OPEN_1);
         end
      end
   end

   assign open_o = open;

   // R1: the window only opens right after the second key on an armed sequencer
   p_open_after_keys_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(key_wr && key_data == KEY_OPEN_2 && key1));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int          PRESC_W = 3,
   parameter logic [31:0] TMO_RST = 32'h0000_FFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ok,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [15:0]        wdata,
   output wdt_ctrl_t          ctrl,
   output logic [31:0]        tmo,
   output logic [31:0]        win,
   output logic [PRESC_W-1:0] presc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= wdt_ctrl_t'(CTRL_RST);
         tmo   <= TMO_RST;
         win   <= '0;
         presc <= '0;
      end else if (wr_ok) begin
         case (addr)
            A_CTRL:  ctrl        <= wdt_ctrl_t'(wdata[CTRL_W-1:0]);
            A_TMO_H: tmo[31:16]  <= wdata;
            A_TMO_L: tmo[15:0]   <= wdata;
            A_WIN_H: win[31:16]  <= wdata;
            A_WIN_L: win[15:0]   <= wdata;
            A_PRESC: presc       <= wdata[PRESC_W-1:0];
            default: ;
         endcase
      end
   end

   // R1: without an accepted write the configuration does not move
   p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_ok) |-> ($stable(tmo) && $stable(win) && $stable(ctrl) && $stable(presc)));

   // R3: a cleared permission bit can never be set again
   p_allow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.allow |=> !ctrl.allow);

endmodule

// File: rtl/wdt_count.sv
module wdt_count
   import wdt_pkg::*;
#(
   parameter int PRESC_W   = 3,
   parameter int GRACE_LEN = 128,
   parameter bit HAS_TEST  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  wdt_run_t           cfg,
   input  logic [31:0]        tmo,
   input  logic [31:0]        win,
   input  logic [PRESC_W-1:0] presc,
   input  logic               lp_tick,
   input  logic               dbg,
   input  logic               stop,
   input  logic               waiting,
   input  logic               svc_wr,
   input  logic [15:0]        svc_data,
   output logic [31:0]        cnt,
   output logic               grace,
   output logic               test_act,
   output logic               rst_req
);
   localparam int GC_W   = $clog2(GRACE_LEN);
   localparam int NBYTES = 4;

   logic [PRESC_W-1:0] pcnt;
   logic [GC_W-1:0]    gcnt;
   logic               armed;
   logic               svc_ok, svc_bad, early, fault;
   logic               paused, run, tick, expired, byte_test;
   logic [31:0]        mask, step;

   assign test_act  = cfg.tst_en & ~cfg.tst_block;
   assign byte_test = test_act & ~cfg.tst_full;

   generate
      if (HAS_TEST) begin : g_test
         for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            logic pick;
            logic inc;
            assign pick = ~byte_test | (cfg.byte_sel == 2'(b));
            assign inc  = byte_test ? (cfg.byte_sel == 2'(b)) : (b == 0);
            assign mask[8*b +: 8] = {8{pick}};
            assign step[8*b +: 8] = {7'd0, inc};
         end
      end else begin : g_plain
         assign mask = '1;
         assign step = 32'd1;
      end
   endgenerate

   assign paused  = (dbg & ~cfg.dbg_run) | (stop & ~cfg.stop_run) | (waiting & ~cfg.wait_run);
   assign run     = (cfg.clk_sel | lp_tick) & ~paused;
   assign tick    = run & (pcnt == presc);
   assign expired = (cnt & mask) >= (tmo & mask);

   assign svc_ok  = svc_wr & armed & (svc_data == KEY_SVC_2);
   assign svc_bad = svc_wr & (armed ? (svc_data != KEY_SVC_2) : (svc_data != KEY_SVC_1));
   assign early   = svc_ok & cfg.win_en & (cnt < win);
   assign fault   = svc_bad | early;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         pcnt    <= '0;
         gcnt    <= '0;
         grace   <= 1'b0;
         armed   <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (!cfg.en) begin
            cnt   <= '0;
            pcnt  <= '0;
            gcnt  <= '0;
            grace <= 1'b0;
            armed <= 1'b0;
         end else begin
            if (svc_wr) armed <= ~armed & (svc_data == KEY_SVC_1);
            if (run)    pcnt  <= (pcnt == presc) ? '0 : pcnt + 1'b1;
            if (fault) begin
               cnt     <= '0;
               grace   <= 1'b0;
               gcnt    <= '0;
               rst_req <= 1'b1;
            end else if (svc_ok) begin
               cnt   <= '0;
               grace <= 1'b0;
               gcnt  <= '0;
            end else if (grace) begin
               if (gcnt == GC_W'(GRACE_LEN - 1)) begin
                  rst_req <= 1'b1;
                  grace   <= 1'b0;
                  cnt     <= '0;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end else if (expired) begin
               grace <= 1'b1;
               gcnt  <= '0;
            end else if (tick) begin
               cnt <= cnt + step;
            end
         end
      end
   end

   // R7: every fault is followed by a reset request
   p_fault_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && fault) |=> rst_req);

   // R6: a valid service leaves the counter at zero
   p_refresh_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && svc_ok) |=> (cnt == 32'd0));

   // R10: a paused counter does not move
   p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && paused && !grace && !svc_ok && !fault) |=> $stable(cnt));

   // R12: a disabled block holds zero and asks for nothing
   p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |=> (cnt == 32'd0 && !rst_req));

   // R9: the grace period ends only by reset, service or disable
   p_grace_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grace) |-> (rst_req || $past(svc_ok) || !$past(cfg.en)));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int          WIN_LEN   = 256,
   parameter int          GRACE_LEN = 128,
   parameter int          PRESC_W   = 3,
   parameter logic [31:0] TMO_RST   = 32'h0000_FFFF,
   parameter bit          HAS_TEST  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lp_tick_i,
   input  logic        dbg_i,
   input  logic        stop_i,
   input  logic        wait_i,
   input  logic        bus_wr_i,
   input  logic [2:0]  bus_addr_i,
   input  logic [15:0] bus_wdata_i,
   output logic [15:0] bus_rdata_o,
   output logic        irq_o,
   output logic        rst_req_o
);

   generate
      if (WIN_LEN < 2)   begin : g_bad_win   $error("WIN_LEN must be at least 2");   end
      if (GRACE_LEN < 2) begin : g_bad_grace $error("GRACE_LEN must be at least 2"); end
      if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_presc
         $error("PRESC_W must lie in 1..16");
      end
   endgenerate

   wdt_ctrl_t          ctrl;
   wdt_run_t           run_cfg;
   logic [31:0]        tmo, win, cnt;
   logic [PRESC_W-1:0] presc;
   logic               open, wr_ok, grace, test_act;

   wdt_unlock #(.WIN_LEN(WIN_LEN)) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (bus_wr_i && bus_addr_i == A_KEY),
      .key_data (bus_wdata_i),
      .open_o   (open)
   );

   assign wr_ok = bus_wr_i & open & ctrl.allow & (bus_addr_i <= A_PRESC);

   wdt_regs #(.PRESC_W(PRESC_W), .TMO_RST(TMO_RST)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_ok (wr_ok),
      .addr  (bus_addr_i),
      .wdata (bus_wdata_i),
      .ctrl  (ctrl),
      .tmo   (tmo),
      .win   (win),
      .presc (presc)
   );

   always_comb begin
      run_cfg.en        = ctrl.en;
      run_cfg.clk_sel   = ctrl.clk_sel;
      run_cfg.win_en    = ctrl.win_en;
      run_cfg.dbg_run   = ctrl.dbg_run;
      run_cfg.stop_run  = ctrl.stop_run;
      run_cfg.wait_run  = ctrl.wait_run;
      run_cfg.tst_full  = ctrl.tst_full;
      run_cfg.byte_sel  = ctrl.byte_sel;
      run_cfg.tst_en    = ctrl.tst_en;
      run_cfg.tst_block = ctrl.tst_block;
   end

   wdt_count #(.PRESC_W(PRESC_W), .GRACE_LEN(GRACE_LEN), .HAS_TEST(HAS_TEST)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (run_cfg),
      .tmo      (tmo),
      .win      (win),
      .presc    (presc),
      .lp_tick  (lp_tick_i),
      .dbg      (dbg_i),
      .stop     (stop_i),
      .waiting  (wait_i),
      .svc_wr   (bus_wr_i && bus_addr_i == A_SVC),
      .svc_data (bus_wdata_i),
      .cnt      (cnt),
      .grace    (grace),
      .test_act (test_act),
      .rst_req  (rst_req_o)
   );

   assign irq_o = grace & ctrl.irq_en & ~test_act;

   always_comb begin
      case (bus_addr_i)
         A_CTRL:  bus_rdata_o = 16'(ctrl);
         A_TMO_H: bus_rdata_o = tmo[31:16];
         A_TMO_L: bus_rdata_o = tmo[15:0];
         A_WIN_H: bus_rdata_o = win[31:16];
         A_WIN_L: bus_rdata_o = win[15:0];
         A_PRESC: bus_rdata_o = 16'(presc);
         A_KEY:   bus_rdata_o = cnt[31:16];
         default: bus_rdata_o = cnt[15:0];
      endcase
   end

   // R11: no early warning while the self-test runs
   p_irq_quiet_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.tst_en && !ctrl.tst_block) |-> !irq_o);

endmodule

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lp_tick = 1'b0, dbg = 1'b0, stop = 1'b0, waitm = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        irq, rst_req;

   int checks = 0;
   int errors = 0;
   bit running = 1'b0;

   always #10 clk = ~clk;

   wdt_keyed uut (
      .clk(clk), .rst_n(rst_n), .lp_tick_i(lp_tick), .dbg_i(dbg), .stop_i(stop),
      .wait_i(waitm), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .irq_o(irq), .rst_req_o(rst_req)
   );

   // ---------------- reference model ----------------
   logic [12:0] m_ctrl;
   logic [31:0] m_tmo, m_win, m_cnt;
   int          m_presc, m_pcnt, m_gcnt, m_wcnt;
   bit          m_open, m_key1, m_armed, m_grace, m_rst;
   // scratch
   bit          t_test, t_bytet, t_src_run, t_tick, t_ok, t_bad, t_fault, t_exp;
   logic [31:0] t_mask, t_step;
   int          t_sel;

   function automatic bit m_irq();
      return m_grace && m_ctrl[2] && !(m_ctrl[11] && !m_ctrl[12]);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 13'h0011; m_tmo = 32'h0000FFFF; m_win = 0; m_cnt = 0;
         m_presc = 0; m_pcnt = 0; m_gcnt = 0; m_wcnt = 0;
         m_open = 0; m_key1 = 0; m_armed = 0; m_grace = 0; m_rst = 0;
      end else begin
         // counter path, from pre-edge state
         t_test  = m_ctrl[11] && !m_ctrl[12];
         t_bytet = t_test && !m_ctrl[8];
         t_sel   = int'(m_ctrl[10:9]);
         t_mask  = t_bytet ? (32'hFF << (8*t_sel)) : 32'hFFFFFFFF;
         t_step  = t_bytet ? (32'd1 << (8*t_sel)) : 32'd1;
         t_src_run = (m_ctrl[1] || lp_tick) && !((dbg && !m_ctrl[5]) || (stop && !m_ctrl[6]) || (waitm && !m_ctrl[7]));
         t_tick  = t_src_run && (m_pcnt == m_presc);
         t_exp   = (m_cnt & t_mask) >= (m_tmo & t_mask);
         t_ok    = bus_wr && bus_addr == 3'd7 && m_armed && bus_wdata == 16'hB480;
         t_bad   = bus_wr && bus_addr == 3'd7 && (m_armed ? bus_wdata != 16'hB480 : bus_wdata != 16'hA602);
         t_fault = t_bad || (t_ok && m_ctrl[3] && m_cnt < m_win);
         m_rst = 0;
         if (!m_ctrl[0]) begin
            m_cnt = 0; m_pcnt = 0; m_gcnt = 0; m_grace = 0; m_armed = 0;
         end else begin
            if (bus_wr && bus_addr == 3'd7) m_armed = !m_armed && bus_wdata == 16'hA602;
            if (t_src_run) m_pcnt = (m_pcnt == m_presc) ? 0 : (m_pcnt + 1) % 8;
            if (t_fault) begin m_cnt = 0; m_grace = 0; m_gcnt = 0; m_rst = 1; end
            else if (t_ok) begin m_cnt = 0; m_grace = 0; m_gcnt = 0; end
            else if (m_grace) begin
               if (m_gcnt == 127) begin m_rst = 1; m_grace = 0; m_cnt = 0; end
               else m_gcnt++;
            end else if (t_exp) begin m_grace = 1; m_gcnt = 0; end
            else if (t_tick) m_cnt = m_cnt + t_step;
         end
         // configuration writes
         if (bus_wr && m_open && m_ctrl[4] && bus_addr <= 3'd5) begin
            case (bus_addr)
               3'd0: m_ctrl = bus_wdata[12:0];
               3'd1: m_tmo[31:16] = bus_wdata;
               3'd2: m_tmo[15:0] = bus_wdata;
               3'd3: m_win[31:16] = bus_wdata;
               3'd4: m_win[15:0] = bus_wdata;
               default: m_presc = int'(bus_wdata[2:0]);
            endcase
         end
         // unlock sequencer
         if (m_open) begin
            if (m_wcnt == 255) m_open = 0; else m_wcnt++;
         end else if (bus_wr && bus_addr == 3'd6) begin
            if (m_key1 && bus_wdata == 16'hD928) begin m_open = 1; m_wcnt = 0; m_key1 = 0; end
            else m_key1 = (bus_wdata == 16'hC520);
         end
      end
   end

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {3'b000, m_ctrl};
         3'd1: return m_tmo[31:16];
         3'd2: return m_tmo[15:0];
         3'd3: return m_win[31:16];
         3'd4: return m_win[15:0];
         3'd5: return 16'(m_presc);
         3'd6: return m_cnt[31:16];
         default: return m_cnt[15:0];
      endcase
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running && rst_n) begin
         chk(rst_req === m_rst, "R9 rst_req vs model", 32'(rst_req), 32'(m_rst));
         chk(irq === m_irq(), "R9 irq vs model", 32'(irq), 32'(m_irq()));
      end
   end

   // all tasks run in the negedge phase
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata === exp, tag, 32'(bus_rdata), 32'(exp));
      chk(bus_rdata === m_read(a), {tag, " vs model"}, 32'(bus_rdata), 32'(m_read(a)));
   endtask

   task automatic unlock();
      wr(3'd6, 16'hC520);
      wr(3'd6, 16'hD928);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   logic [15:0] a0;
   int          c;
   bit          seen;

   initial begin
      idle(3);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);

      // R4 reset values; R5 no lp_tick pulses means no count
      rd(3'd0, 16'h0011, "R4 ctrl reset");
      rd(3'd1, 16'h0000, "R4 tmo hi reset");
      rd(3'd2, 16'hFFFF, "R4 tmo lo reset");
      rd(3'd4, 16'h0000, "R4 win reset");
      rd(3'd5, 16'h0000, "R4 presc reset");
      idle(5);
      rd(3'd7, 16'h0000, "R5 lp source idle");

      // R1 locked writes, wrong order, interposed word
      wr(3'd2, 16'h1234);
      rd(3'd2, 16'hFFFF, "R1 write while locked");
      wr(3'd6, 16'hD928); wr(3'd6, 16'hC520); wr(3'd2, 16'h1234);
      rd(3'd2, 16'hFFFF, "R1 reversed keys");
      wr(3'd6, 16'h1111); wr(3'd6, 16'hD928); wr(3'd2, 16'h1234);
      rd(3'd2, 16'hFFFF, "R1 interposed word");

      // R2 window edges: edge 256 accepted, edge 257 rejected
      unlock(); idle(255); wr(3'd2, 16'h00AA);
      rd(3'd2, 16'h00AA, "R2 last open edge");
      unlock(); idle(256); wr(3'd2, 16'h00BB);
      rd(3'd2, 16'h00AA, "R2 first closed edge");

      // R5 bus clock source, divide by 2
      unlock();
      wr(3'd1, 16'h0000); wr(3'd2, 16'h0040); wr(3'd5, 16'h0001); wr(3'd0, 16'h0017);
      idle(6);
      bus_addr = 3'd7; #1; a0 = bus_rdata;
      idle(10);
      rd(3'd7, a0 + 16'd5, "R5 prescaled rate");

      // R6 service clears
      wr(3'd7, 16'hA602); wr(3'd7, 16'hB480);
      rd(3'd7, 16'h0000, "R6 counter cleared");

      // R9 expiry, 128 cycles of warning then reset
      c = 0;
      while (!irq && c < 1000) begin @(negedge clk); c++; end
      chk(irq === 1'b1, "R9 warning raised", 32'(irq), 32'd1);
      c = 0;
      while (!rst_req && c < 1000) begin @(negedge clk); c++; end
      chk(c == 128, "R9 warning length", 32'(c), 32'd128);
      rd(3'd7, 16'h0000, "R9 counter restarts");

      // R7 bad service words
      wr(3'd7, 16'h1111);
      chk(rst_req === 1'b1, "R7 bad first word", 32'(rst_req), 32'd1);
      wr(3'd7, 16'hA602); wr(3'd7, 16'h2222);
      chk(rst_req === 1'b1, "R7 bad second word", 32'(rst_req), 32'd1);

      // R8 window mode
      unlock();
      wr(3'd3, 16'h0000); wr(3'd4, 16'h0010); wr(3'd0, 16'h001F);
      wr(3'd7, 16'h0000);
      wr(3'd7, 16'hA602); wr(3'd7, 16'hB480);
      chk(rst_req === 1'b1, "R8 early service", 32'(rst_req), 32'd1);
      idle(40);
      wr(3'd7, 16'hA602); wr(3'd7, 16'hB480);
      chk(rst_req === 1'b0, "R8 service inside window", 32'(rst_req), 32'd0);
      rd(3'd7, 16'h0000, "R8 counter cleared");

      // R10 debug pause
      unlock();
      wr(3'd0, 16'h0013);
      dbg = 1'b1;
      bus_addr = 3'd7; #1; a0 = bus_rdata;
      idle(20);
      rd(3'd7, a0, "R10 held in debug");
      stop = 1'b1; dbg = 1'b0;
      idle(10);
      rd(3'd7, a0, "R10 held in stop");
      stop = 1'b0; dbg = 1'b1;
      wr(3'd0, 16'h0033);
      bus_addr = 3'd7; #1; a0 = bus_rdata;
      idle(10);
      rd(3'd7, a0 + 16'd5, "R10 runs in debug when allowed");
      dbg = 1'b0;

      // R11 byte lane test mode, lane 1
      unlock();
      wr(3'd5, 16'h0000);
      idle(10);
      wr(3'd1, 16'h0000); wr(3'd2, 16'h0300); wr(3'd0, 16'h0A17);
      wr(3'd7, 16'hA602); wr(3'd7, 16'hB480);
      idle(2);
      rd(3'd7, 16'h0200, "R11 lane step");
      rd(3'd6, 16'h0000, "R11 upper lanes idle");
      seen = 1'b0; c = 0;
      while (!rst_req && c < 400) begin
         @(negedge clk); c++;
         if (irq) seen = 1'b1;
      end
      chk(rst_req === 1'b1, "R11 lane expiry resets", 32'(rst_req), 32'd1);
      chk(seen == 1'b0, "R11 warning suppressed", 32'(seen), 32'd0);
      unlock();
      wr(3'd0, 16'h1A17);
      wr(3'd7, 16'hA602); wr(3'd7, 16'hB480);
      idle(2);
      rd(3'd7, 16'h0002, "R11 test blocked");

      // R12 disabled
      unlock();
      wr(3'd0, 16'h0010);
      idle(10);
      rd(3'd7, 16'h0000, "R12 counter held");
      wr(3'd7, 16'h5555);
      chk(rst_req === 1'b0, "R12 service ignored", 32'(rst_req), 32'd0);

      // R3 permission cleared
      unlock();
      wr(3'd0, 16'h0000);
      unlock();
      wr(3'd2, 16'h7777);
      rd(3'd2, 16'h0300, "R3 locked after permission cleared");
      rd(3'd0, 16'h0000, "R3 control frozen");

      idle(4);
      report();
   end

endmodule